// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the two SMBus wires and detects two bus conditions. The first is a clock-stuck condition: SCL held low for longer than a timeout measured in millisecond ticks (25 by default). The second is a bus-idle condition: SCL and SDA both held high for more than a set number of clock-source overflow periods (10 by default). Each detector has its own enable. The shifter, arbitration logic and interface reset all sit outside this block.

Both wire inputs first pass through a synchroniser with a parameter-selected number of stages. The low-timeout detector counts millisecond ticks only while the synchronised SCL is low. Whenever SCL is high, or its enable is clear, the count returns to zero. When the count reaches the timeout, a sticky flag is raised. Software acts on the flag by disabling and re-enabling the interface, and then clears the flag through a clear strobe.

The free detector counts source overflows while both wires are high. On the overflow that takes the count past the threshold, it emits a single-cycle event. Surrounding logic treats that event exactly like a detected STOP: it raises an interrupt request and sets the STOP status. The event fires once per idle stretch.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After reset, `low_to_flag` and `free_evt` are both 0.
- R2: With `low_en` = 1 and synchronised SCL held low, `low_to_flag` becomes 1 on the `LOW_TIMEOUT_MS`-th (default 25) `ms_tick` pulse. It is still 0 after one tick fewer.
- R3: While synchronised SCL is high, the low-timeout count is held at zero and `ms_tick` has no effect. A low period therefore needs a full `LOW_TIMEOUT_MS` ticks on its own to set the flag.
- R4: While `low_en` = 0, the low-timeout count is held at zero and the flag cannot be set. After re-enabling, a full `LOW_TIMEOUT_MS` ticks are needed.
- R5: Once set, `low_to_flag` stays 1, even when SCL returns high, until a `low_clr` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R6: With `free_en` = 1 and both synchronised lines high, `free_evt` pulses high for exactly one cycle on the (`FREE_PERIODS`+1)-th `src_ovf` pulse (default 11th). It stays low after `FREE_PERIODS` pulses.
- R7: Once the event has fired, further `src_ovf` pulses during the same idle stretch produce no further events. A new idle stretch, begun after either line has gone low, can fire again.
- R8: Either line going low restarts the free count from zero.
- R9: While `free_en` = 0, `free_evt` stays 0 and the free count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_ovf | input | 1 | One-cycle clock-source overflow strobe |
| ms_tick | input | 1 | One-cycle millisecond tick |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| low_en | input | 1 | Enable for the SCL low timeout |
| free_en | input | 1 | Enable for the bus-free timeout |
| low_clr | input | 1 | Software clear strobe for `low_to_flag` |
| low_to_flag | output | 1 | Sticky SCL-low-timeout flag; requests an interface reset |
| free_evt | output | 1 | One-cycle bus-free event, treated as a STOP |

## Verification
If a counter is off by one, the flag or the event shows up one tick or one overflow early or late. The bench brackets each threshold: it checks one pulse before the threshold and then the threshold pulse itself. A count that is not reloaded by a high SCL, a low line or a cleared enable shows up as a premature flag or event within the next full window. A broken one-shot latch in the free detector shows up within a few overflows as extra events. A wrong flag-hold path shows up as soon as SCL returns high.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;
   // Index of the two wires inside the synchroniser vector.
   localparam int unsigned LINE_SCL = 0;
   localparam int unsigned LINE_SDA = 1;
   localparam int unsigned N_LINES  = 2;

   // Counter width able to hold values 0..max_val.
   function automatic int unsigned cnt_width(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction
endpackage

// File: rtl/smbus_tmo_sync.sv
module smbus_tmo_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("smbus_tmo_sync: WIDTH must be at least 1");
      end
      if (STAGES == 0) begin : g_bypass
         assign q_out = d_in;
      end else begin : g_chain
         for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  chain <= '1;   // wires idle high
               end else if (STAGES == 1) begin
                  chain[0] <= d_in[b];
               end else begin
                  chain <= {chain[STAGES-2:0], d_in[b]};
               end
            end
            assign q_out[b] = chain[STAGES-1];
         end
      end
   endgenerate
endmodule

// File: rtl/smbus_low_tmo.sv
module smbus_low_tmo #(
   parameter int unsigned LIMIT = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic line_hi,
   input  logic tick,
   input  logic clr,
   output logic flag
);
   import smbus_tmo_pkg::*;
   localparam int unsigned CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
   localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("smbus_low_tmo: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          counting;
   logic          hit;

   assign counting = en && !line_hi;
   assign hit      = counting && tick && (cnt == LAST_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!counting) begin
         cnt <= '0;                      // reload while SCL high or disabled
      end else if (tick && (cnt != LIM_V)) begin
         cnt <= cnt + 1'b1;              // saturates at LIMIT
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hit) begin
         flag <= 1'b1;                   // set beats clear
      end else if (clr) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/smbus_free_tmo.sv
module smbus_free_tmo #(
   parameter int unsigned PERIODS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic scl_hi,
   input  logic sda_hi,
   input  logic ovf,
   output logic evt
);
   import smbus_tmo_pkg::*;
   // Count runs 0..PERIODS+1; PERIODS+1 marks "already fired".
   localparam int unsigned CW = cnt_width(PERIODS + 1);
   localparam logic [CW-1:0] FIRE_V = CW'(PERIODS);
   localparam logic [CW-1:0] DONE_V = CW'(PERIODS + 1);

   generate
      if (PERIODS < 1) begin : g_bad_periods
         $error("smbus_free_tmo: PERIODS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          idle;
   logic          fire;

   assign idle = en && scl_hi && sda_hi;
   assign fire = idle && ovf && (cnt == FIRE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!idle) begin
         cnt <= '0;
      end else if (ovf && (cnt != DONE_V)) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt <= 1'b0;
      else        evt <= fire;
   end
endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon #(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned LOW_TIMEOUT_MS = 25,
   parameter int unsigned FREE_PERIODS   = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_ovf,
   input  logic ms_tick,
   input  logic scl_in,
   input  logic sda_in,
   input  logic low_en,
   input  logic free_en,
   input  logic low_clr,
   output logic low_to_flag,
   output logic free_evt
);
   import smbus_tmo_pkg::*;

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] sync_lines;
   logic               scl_s;
   logic               sda_s;

   assign raw_lines[LINE_SCL] = scl_in;
   assign raw_lines[LINE_SDA] = sda_in;
   assign scl_s = sync_lines[LINE_SCL];
   assign sda_s = sync_lines[LINE_SDA];

   smbus_tmo_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_lines),
      .q_out (sync_lines)
   );

   smbus_low_tmo #(
      .LIMIT (LOW_TIMEOUT_MS)
   ) u_low (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (low_en),
      .line_hi (scl_s),
      .tick    (ms_tick),
      .clr     (low_clr),
      .flag    (low_to_flag)
   );

   smbus_free_tmo #(
      .PERIODS (FREE_PERIODS)
   ) u_free (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (free_en),
      .scl_hi (scl_s),
      .sda_hi (sda_s),
      .ovf    (src_ovf),
      .evt    (free_evt)
   );
endmodule

// File: rtl/smbus_timeout_mon_chk.sv
module smbus_timeout_mon_chk (
   input logic clk,
   input logic rst_n,
   input logic src_ovf,
   input logic ms_tick,
   input logic low_en,
   input logic free_en,
   input logic low_clr,
   input logic scl_s,
   input logic sda_s,
   input logic low_to_flag,
   input logic free_evt
);
   // R5: flag holds until cleared
   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (low_to_flag && !low_clr) |=> low_to_flag);

   // R2/R3/R4: a rise needs an enabled tick with SCL low
   p_rise_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_to_flag) |-> $past(low_en && !scl_s && ms_tick));

   // R6: event follows an overflow while idle and enabled
   p_evt_needs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      free_evt |-> $past(free_en && scl_s && sda_s && src_ovf));

   // R7: one-cycle event
   p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      free_evt |=> !free_evt);

   // R9: disabled detector stays silent
   p_no_evt_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !free_en |=> !free_evt);
endmodule

bind smbus_timeout_mon smbus_timeout_mon_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_ovf     (src_ovf),
   .ms_tick     (ms_tick),
   .low_en      (low_en),
   .free_en     (free_en),
   .low_clr     (low_clr),
   .scl_s       (scl_s),
   .sda_s       (sda_s),
   .low_to_flag (low_to_flag),
   .free_evt    (free_evt)
);

// File: tb/smbus_timeout_mon_bench.sv
`timescale 1ns/1ps
module smbus_timeout_mon_bench;
   localparam int LOW_N  = 25;
   localparam int FREE_N = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic src_ovf = 1'b0, ms_tick = 1'b0;
   logic scl_in = 1'b1, sda_in = 1'b1;
   logic low_en = 1'b0, free_en = 1'b0, low_clr = 1'b0;
   logic low_to_flag, free_evt;

   int n_checks = 0;
   int n_fail   = 0;
   int evt_seen = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   smbus_timeout_mon u_smbus_timeout_mon (
      .clk(clk), .rst_n(rst_n), .src_ovf(src_ovf), .ms_tick(ms_tick),
      .scl_in(scl_in), .sda_in(sda_in), .low_en(low_en), .free_en(free_en),
      .low_clr(low_clr), .low_to_flag(low_to_flag), .free_evt(free_evt)
   );

   // count event pulses, sampled away from the active edge
   always @(negedge clk) if (rst_n && free_evt) evt_seen++;

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
         idle(2);
      end
   endtask

   task automatic ovf(input int n);
      repeat (n) begin
         @(negedge clk) src_ovf = 1'b1;
         @(negedge clk) src_ovf = 1'b0;
         idle(2);
      end
   endtask

   task automatic set_lines(input logic scl, input logic sda);
      @(negedge clk);
      scl_in = scl;
      sda_in = sda;
      idle(4);   // beyond the synchroniser latency
   endtask

   task automatic clear_flag();
      @(negedge clk) low_clr = 1'b1;
      @(negedge clk) low_clr = 1'b0;
      idle(1);
   endtask

   task automatic t_reset();
      check("R1 flag at reset", int'(low_to_flag), 0);
      check("R1 event at reset", int'(free_evt), 0);
   endtask

   task automatic t_low_basic();
      low_en = 1'b1;
      set_lines(1'b0, 1'b1);
      tick(LOW_N - 1);
      check("R2 flag one tick early", int'(low_to_flag), 0);
      tick(1);
      check("R2 flag at timeout", int'(low_to_flag), 1);
   endtask

   task automatic t_sticky();
      set_lines(1'b1, 1'b1);
      tick(3);
      check("R5 flag held with SCL high", int'(low_to_flag), 1);
      clear_flag();
      check("R5 flag cleared", int'(low_to_flag), 0);
   endtask

   task automatic t_low_reload();
      set_lines(1'b0, 1'b1);
      tick(20);
      set_lines(1'b1, 1'b1);
      tick(5);
      set_lines(1'b0, 1'b1);
      tick(20);
      check("R3 reload by SCL high", int'(low_to_flag), 0);
      tick(LOW_N - 20);
      check("R3 full window after reload", int'(low_to_flag), 1);
      set_lines(1'b1, 1'b1);
      clear_flag();
   endtask

   task automatic t_low_disable();
      low_en = 1'b0;
      set_lines(1'b0, 1'b1);
      tick(LOW_N + 5);
      check("R4 disabled no flag", int'(low_to_flag), 0);
      low_en = 1'b1;
      tick(20);
      @(negedge clk) low_en = 1'b0;
      @(negedge clk) low_en = 1'b1;
      tick(20);
      check("R4 reset by disable", int'(low_to_flag), 0);
      tick(LOW_N - 20);
      check("R4 full window after enable", int'(low_to_flag), 1);
      low_en = 1'b0;
      set_lines(1'b1, 1'b1);
      clear_flag();
   endtask

   task automatic t_free_basic();
      int base;
      free_en = 1'b1;
      set_lines(1'b1, 1'b1);
      base = evt_seen;
      ovf(FREE_N);
      check("R6 no event at threshold", evt_seen - base, 0);
      ovf(1);
      check("R6 event past threshold", evt_seen - base, 1);
      ovf(20);
      check("R7 single event per idle", evt_seen - base, 1);
      set_lines(1'b0, 1'b1);
      set_lines(1'b1, 1'b1);
      ovf(FREE_N + 1);
      check("R7 new idle fires again", evt_seen - base, 2);
   endtask

   task automatic t_free_restart();
      int base;
      set_lines(1'b0, 1'b1);
      set_lines(1'b1, 1'b1);
      base = evt_seen;
      ovf(8);
      set_lines(1'b1, 1'b0);
      set_lines(1'b1, 1'b1);
      ovf(FREE_N);
      check("R8 SDA low restarts count", evt_seen - base, 0);
      ovf(1);
      check("R8 event after restart", evt_seen - base, 1);
   endtask

   task automatic t_free_disable();
      int base;
      free_en = 1'b0;
      set_lines(1'b0, 1'b1);
      set_lines(1'b1, 1'b1);
      base = evt_seen;
      ovf(FREE_N + 5);
      check("R9 disabled no event", evt_seen - base, 0);
      free_en = 1'b1;
      ovf(FREE_N + 1);
      check("R9 count held while disabled", evt_seen - base, 1);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_low_basic();
      t_sticky();
      t_low_reload();
      t_low_disable();
      t_free_basic();
      t_free_restart();
      t_free_disable();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule